// File: doc/BRIEF.md
# Audio interface global register file

This block is the global control and status section of a bus-attached audio streaming device. A host reaches it through a simple request/response port that carries quadlet reads, quadlet writes and 64-bit compare-swap requests. The section holds the owner address, the last event bitmask, the clock selection, the stream enable, the current clock status and a lock/slip word that covers every clock source. Clock-source monitors outside the block drive the lock and slip indications as plain signals.

When events occur, the block stores the new event set and raises an outbound notification write. The write carries the event bits and goes to the 64-bit address that the current owner claimed with compare-swap. The owner field is cleared by a bus-reset pulse, and so is the stream enable. Slip flags stay set until software reads them. Lock flags follow their inputs, and any change in them raises an event.

Top module: `agr_glob_regs`

## Requirements
- R1: After `rst_ni` is released or after a `bus_reset_i` pulse, the owner reads as 0xFFFF_0000_0000_0000 (no owner) and `stream_en_o` is 0. The owner high word is at offset 0x00 and the low word at offset 0x04.
- R2: A compare-swap request at offset 0x00 returns the old 64-bit owner value on `rsp_rdata_o`. It writes `req_swap_i` only when the old value equals `req_cmp_i`. A compare-swap at any other offset is answered with an error.
- R3: A plain write to offset 0x00 or 0x04 is answered with an error, and the owner value does not change.
- R4: These requests get an error response and have no effect: a misaligned access (`req_addr_i[1:0]` != 0), an unmapped offset, op code 3, and a write to a read-only register (0x08 events, 0x14 clock status, 0x18 source status). Op codes are 0 read, 1 write, 2 compare-swap.
- R5: The clock select register at 0x0C resets to 0x020C. A write stores bits 15:0 (source code in bits 7:0, rate code in bits 15:8) and drives them on `clk_sel_o`. The accepted write raises event bit 5.
- R6: A write to 0x10 sets `stream_en_o` when the data is non-zero and clears it when the data is zero. A read returns 0 or 1.
- R7: The event register at 0x08 uses bit 0 for receive config change, bit 1 for transmit config change, bit 4 for current-source lock change, bit 5 for clock select accepted and bit 6 for source lock change. A new event set replaces the earlier value. Reading the register does not clear it.
- R8: While an owner is set, an event set goes out in the cycle after it occurs as `ntf_valid_o`, with `ntf_data_o` set to the event bits and `ntf_addr_o` set to the owner value. Data and address stay stable until `ntf_ready_i` is seen.
- R9: While the owner is the no-owner value, no notification is issued. Events gathered since the last bus reset are sent in the cycle after an owner is claimed.
- R10: Events that arrive while a notification is stalled are OR-merged into the next notification. That notification is issued on the same edge that completes the handshake.
- R11: Source status at 0x18 shows the registered lock inputs in bits 10:0, and any change of `src_lock_i` raises event bit 6. Clock status at 0x14 shows the current lock in bit 0 and the rate code in bits 15:8, and a change of `cur_locked_i` raises event bit 4.
- R12: Source status bits 26:16 are sticky slip flags. A slip raises no notification. A read of 0x18 returns the flags and then clears them, but a slip that arrives in the same cycle as the read stays set.
- R13: Every request gets exactly one response, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | Bus-reset pulse |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr_i | input | ADDR_W | Byte offset |
| req_wdata_i | input | 32 | Write data |
| req_cmp_i | input | 64 | Compare-swap compare operand |
| req_swap_i | input | 64 | Compare-swap new value |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Request refused |
| rsp_rdata_o | output | 64 | Read data or old owner value |
| ntf_valid_o | output | 1 | Notification write pending |
| ntf_ready_i | input | 1 | Notification accepted |
| ntf_addr_o | output | 64 | Notification target address |
| ntf_data_o | output | 32 | Notification event bits |
| rx_cfg_chg_i | input | 1 | Receive config change pulse |
| tx_cfg_chg_i | input | 1 | Transmit config change pulse |
| cur_locked_i | input | 1 | Current source locked |
| cur_rate_i | input | RATE_W | Current nominal rate code |
| src_lock_i | input | NUM_SRC | Per-source lock |
| src_slip_i | input | NUM_SRC | Per-source slip pulse |
| clk_sel_o | output | 16 | Selected source and rate |
| stream_en_o | output | 1 | Streams enabled |

## Verification
A corrupted owner value shows up at once: the next read or compare-swap of offset 0x00 returns it, and the next notification carries it on `ntf_addr_o`, one cycle after the event. A wrong merge or replace state in the event path changes `ntf_data_o` on the handshake edge, or changes the value read from 0x08. A slip flag that sticks shows up on the second read of 0x18, and a flag that is lost shows up on the first read after the slip.

// File: rtl/agr_pkg.sv
package agr_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_CAS = 2'd2
  } agr_op_e;

  localparam int unsigned OWN_W  = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 16;
  localparam logic [OWN_W-1:0] NO_OWNER = 64'hFFFF_0000_0000_0000;
  localparam logic [SEL_W-1:0] CLK_SEL_RST = 16'h020C;

  localparam int unsigned OFS_OWN_HI  = 'h00;
  localparam int unsigned OFS_OWN_LO  = 'h04;
  localparam int unsigned OFS_EVENTS  = 'h08;
  localparam int unsigned OFS_CLK_SEL = 'h0C;
  localparam int unsigned OFS_STR_EN  = 'h10;
  localparam int unsigned OFS_CLK_ST  = 'h14;
  localparam int unsigned OFS_SRC_ST  = 'h18;

  localparam int unsigned EVB_RX       = 0;
  localparam int unsigned EVB_TX       = 1;
  localparam int unsigned EVB_CUR_LOCK = 4;
  localparam int unsigned EVB_CLK_ACC  = 5;
  localparam int unsigned EVB_SRC_LOCK = 6;

  localparam int unsigned SLIP_LSB = 16;
endpackage

// File: rtl/agr_owner.sv
module agr_owner
  import agr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             cas_i,
  input  logic [OWN_W-1:0] cmp_i,
  input  logic [OWN_W-1:0] swap_i,
  output logic [OWN_W-1:0] owner_o
);
  logic [OWN_W-1:0] owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          owner_q <= NO_OWNER;
    else if (bus_reset_i)                 owner_q <= NO_OWNER;
    else if (cas_i && (owner_q == cmp_i)) owner_q <= swap_i;
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/agr_src_status.sv
module agr_src_status #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lock_i,
  input  logic [NUM_SRC-1:0] slip_i,
  input  logic               rd_clr_i,
  output logic [NUM_SRC-1:0] lock_o,
  output logic [NUM_SRC-1:0] slip_o,
  output logic               lock_chg_o
);
  logic [NUM_SRC-1:0] lock_q;
  logic [NUM_SRC-1:0] slip_q;
  logic [NUM_SRC-1:0] chg;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lock_q[g] <= 1'b0;
        slip_q[g] <= 1'b0;
      end else begin
        lock_q[g] <= lock_i[g];
        // a slip in the read cycle survives the clear
        slip_q[g] <= (slip_q[g] & ~rd_clr_i) | slip_i[g];
      end
    end
    assign chg[g] = lock_i[g] ^ lock_q[g];
  end

  assign lock_o     = lock_q;
  assign slip_o     = slip_q;
  assign lock_chg_o = |chg;
endmodule

// File: rtl/agr_notifier.sv
module agr_notifier
  import agr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic [WORD_W-1:0] ev_i,
  input  logic [OWN_W-1:0]  owner_i,
  output logic [WORD_W-1:0] events_o,
  output logic              ntf_valid_o,
  input  logic              ntf_ready_i,
  output logic [OWN_W-1:0]  ntf_addr_o,
  output logic [WORD_W-1:0] ntf_data_o
);
  logic [WORD_W-1:0] events_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_nxt;
  logic              vld_q;
  logic [OWN_W-1:0]  addr_q;
  logic [WORD_W-1:0] data_q;
  logic              stage_free;
  logic              owned;
  logic              launch;

  assign acc_nxt    = acc_q | ev_i;
  assign stage_free = !vld_q || ntf_ready_i;
  assign owned      = owner_i != NO_OWNER;
  assign launch     = stage_free && owned && (|acc_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      events_q <= '0;
      acc_q    <= '0;
      vld_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (|ev_i) events_q <= ev_i;
      if (launch) begin
        acc_q  <= '0;
        vld_q  <= 1'b1;
        addr_q <= owner_i;
        data_q <= acc_nxt;
      end else begin
        acc_q <= bus_reset_i ? ev_i : acc_nxt;
        if (stage_free) vld_q <= 1'b0;
      end
    end
  end

  assign events_o    = events_q;
  assign ntf_valid_o = vld_q;
  assign ntf_addr_o  = addr_q;
  assign ntf_data_o  = data_q;
endmodule

// File: rtl/agr_glob_regs.sv
module agr_glob_regs
  import agr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned RATE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_reset_i,
  input  logic               req_valid_i,
  input  logic [1:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [31:0]        req_wdata_i,
  input  logic [63:0]        req_cmp_i,
  input  logic [63:0]        req_swap_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [63:0]        rsp_rdata_o,
  output logic               ntf_valid_o,
  input  logic               ntf_ready_i,
  output logic [63:0]        ntf_addr_o,
  output logic [31:0]        ntf_data_o,
  input  logic               rx_cfg_chg_i,
  input  logic               tx_cfg_chg_i,
  input  logic               cur_locked_i,
  input  logic [RATE_W-1:0]  cur_rate_i,
  input  logic [NUM_SRC-1:0] src_lock_i,
  input  logic [NUM_SRC-1:0] src_slip_i,
  output logic [15:0]        clk_sel_o,
  output logic               stream_en_o
);
  logic [OWN_W-1:0]   owner;
  logic [WORD_W-1:0]  events;
  logic [WORD_W-1:0]  ev;
  logic [NUM_SRC-1:0] lock_st;
  logic [NUM_SRC-1:0] slip_st;
  logic               src_chg;

  logic [SEL_W-1:0]   clk_sel_q;
  logic               en_q;
  logic               cur_lock_q;
  logic [RATE_W-1:0]  cur_rate_q;

  logic               cas_en, sel_we, en_we, src_rd;
  logic               err;
  logic [63:0]        rdata;
  logic               rsp_valid_q, rsp_err_q;
  logic [63:0]        rsp_rdata_q;
  agr_op_e            op;

  assign op = agr_op_e'(req_op_i);

  always_comb begin
    cas_en = 1'b0;
    sel_we = 1'b0;
    en_we  = 1'b0;
    src_rd = 1'b0;
    err    = 1'b0;
    rdata  = '0;
    if (req_valid_i) begin
      if (req_addr_i[1:0] != 2'b00) begin
        err = 1'b1;
      end else begin
        unique case (op)
          OP_CAS: begin
            if (req_addr_i == ADDR_W'(OFS_OWN_HI)) begin
              cas_en = 1'b1;
              rdata  = owner;
            end else err = 1'b1;
          end
          OP_RD: begin
            case (req_addr_i)
              ADDR_W'(OFS_OWN_HI):  rdata = 64'(owner[63:32]);
              ADDR_W'(OFS_OWN_LO):  rdata = 64'(owner[31:0]);
              ADDR_W'(OFS_EVENTS):  rdata = 64'(events);
              ADDR_W'(OFS_CLK_SEL): rdata = 64'(clk_sel_q);
              ADDR_W'(OFS_STR_EN):  rdata = 64'(en_q);
              ADDR_W'(OFS_CLK_ST):  rdata = 64'({cur_rate_q, 7'b0, cur_lock_q});
              ADDR_W'(OFS_SRC_ST): begin
                rdata  = (64'(slip_st) << SLIP_LSB) | 64'(lock_st);
                src_rd = 1'b1;
              end
              default: err = 1'b1;
            endcase
          end
          OP_WR: begin
            case (req_addr_i)
              ADDR_W'(OFS_CLK_SEL): sel_we = 1'b1;
              ADDR_W'(OFS_STR_EN):  en_we  = 1'b1;
              default:              err    = 1'b1;
            endcase
          end
          default: err = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    ev               = '0;
    ev[EVB_RX]       = rx_cfg_chg_i;
    ev[EVB_TX]       = tx_cfg_chg_i;
    ev[EVB_CUR_LOCK] = cur_locked_i ^ cur_lock_q;
    ev[EVB_CLK_ACC]  = sel_we;
    ev[EVB_SRC_LOCK] = src_chg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q   <= CLK_SEL_RST;
      en_q        <= 1'b0;
      cur_lock_q  <= 1'b0;
      cur_rate_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (sel_we) clk_sel_q <= req_wdata_i[SEL_W-1:0];
      if (bus_reset_i) en_q <= 1'b0;
      else if (en_we)  en_q <= |req_wdata_i;
      cur_lock_q  <= cur_locked_i;
      cur_rate_q  <= cur_rate_i;
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= err;
      rsp_rdata_q <= rdata;
    end
  end

  agr_owner i_owner (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .cas_i       (cas_en),
    .cmp_i       (req_cmp_i),
    .swap_i      (req_swap_i),
    .owner_o     (owner)
  );

  agr_src_status #(.NUM_SRC(NUM_SRC)) i_src_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (src_lock_i),
    .slip_i     (src_slip_i),
    .rd_clr_i   (src_rd),
    .lock_o     (lock_st),
    .slip_o     (slip_st),
    .lock_chg_o (src_chg)
  );

  agr_notifier i_notifier (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .ev_i        (ev),
    .owner_i     (owner),
    .events_o    (events),
    .ntf_valid_o (ntf_valid_o),
    .ntf_ready_i (ntf_ready_i),
    .ntf_addr_o  (ntf_addr_o),
    .ntf_data_o  (ntf_data_o)
  );

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign clk_sel_o   = clk_sel_q;
  assign stream_en_o = en_q;
endmodule

// File: rtl/agr_checker.sv
module agr_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              ntf_valid_o,
  input logic              ntf_ready_i,
  input logic [63:0]       ntf_addr_o,
  input logic [31:0]       ntf_data_o,
  input logic              stream_en_o
);
  // R13
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R13
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R4
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[1:0] != 2'b00) |=> rsp_err_o);
  // R3
  owner_wr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd1 && req_addr_i[ADDR_W-1:3] == '0) |=> rsp_err_o);
  // R1
  bus_rst_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !stream_en_o);
  // R8
  ntf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_valid_o && !ntf_ready_i) |=> (ntf_valid_o && $stable(ntf_data_o) && $stable(ntf_addr_o)));
  // R9
  ntf_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> (ntf_addr_o[63:48] != 16'hFFFF));
  // R8
  ntf_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> (ntf_data_o != '0));
endmodule

bind agr_glob_regs agr_checker #(.ADDR_W(ADDR_W)) i_agr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .ntf_valid_o (ntf_valid_o),
  .ntf_ready_i (ntf_ready_i),
  .ntf_addr_o  (ntf_addr_o),
  .ntf_data_o  (ntf_data_o),
  .stream_en_o (stream_en_o)
);

// File: tb/test_agr_glob_regs.sv
module test_agr_glob_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] NO_OWN = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] OWN_A  = 64'h0001_0000_0000_1000;
  localparam logic [63:0] OWN_B  = 64'h0002_0000_0000_2000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'd0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [63:0] req_cmp_i = '0;
  logic [63:0] req_swap_i = '0;
  logic        rsp_valid_o, rsp_err_o;
  logic [63:0] rsp_rdata_o;
  logic        ntf_valid_o;
  logic        ntf_ready_i = 1'b0;
  logic [63:0] ntf_addr_o;
  logic [31:0] ntf_data_o;
  logic        rx_cfg_chg_i = 1'b0;
  logic        tx_cfg_chg_i = 1'b0;
  logic        cur_locked_i = 1'b0;
  logic [7:0]  cur_rate_i = '0;
  logic [10:0] src_lock_i = '0;
  logic [10:0] src_slip_i = '0;
  logic [15:0] clk_sel_o;
  logic        stream_en_o;

  int checks = 0;
  int fails  = 0;
  logic        r_err, r_vld;
  logic [63:0] r_data;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  agr_glob_regs i_agr_glob_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_cmp_i(req_cmp_i), .req_swap_i(req_swap_i),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
    .ntf_valid_o(ntf_valid_o), .ntf_ready_i(ntf_ready_i), .ntf_addr_o(ntf_addr_o),
    .ntf_data_o(ntf_data_o), .rx_cfg_chg_i(rx_cfg_chg_i), .tx_cfg_chg_i(tx_cfg_chg_i),
    .cur_locked_i(cur_locked_i), .cur_rate_i(cur_rate_i), .src_lock_i(src_lock_i),
    .src_slip_i(src_slip_i), .clk_sel_o(clk_sel_o), .stream_en_o(stream_en_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [7:0] addr,
                        input logic [31:0] wd, input logic [63:0] cmp, input logic [63:0] swp);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr;
    req_wdata_i = wd; req_cmp_i = cmp; req_swap_i = swp;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    r_vld = rsp_valid_o; r_err = rsp_err_o; r_data = rsp_rdata_o;
  endtask

  task automatic rd(input logic [7:0] addr);
    do_req(2'd0, addr, '0, '0, '0);
  endtask

  task automatic t_reset();
    chk("R1 stream_en after reset", 64'(stream_en_o), 0);
    chk("R5 clk_sel reset", 64'(clk_sel_o), 64'h020C);
    chk("R8 no notification after reset", 64'(ntf_valid_o), 0);
    rd(8'h00);
    chk("R13 response strobe", 64'(r_vld), 1);
    chk("R1 owner hi", r_data, 64'hFFFF0000);
    rd(8'h04);
    chk("R1 owner lo", r_data, 0);
  endtask

  task automatic t_access_rules();
    rd(8'h02);
    chk("R4 misaligned read err", 64'(r_err), 1);
    rd(8'h40);
    chk("R4 unmapped read err", 64'(r_err), 1);
    do_req(2'd1, 8'h08, 32'h7F, '0, '0);
    chk("R4 write events err", 64'(r_err), 1);
    do_req(2'd1, 8'h14, 32'h1, '0, '0);
    chk("R4 write clock status err", 64'(r_err), 1);
    do_req(2'd3, 8'h0C, 32'h0, '0, '0);
    chk("R4 op3 err", 64'(r_err), 1);
    do_req(2'd1, 8'h0E, 32'h0101, '0, '0);
    chk("R4 misaligned write err", 64'(r_err), 1);
    chk("R4 clk_sel untouched", 64'(clk_sel_o), 64'h020C);
    rd(8'h08);
    chk("R4 events untouched", r_data, 0);
  endtask

  task automatic t_owner();
    do_req(2'd1, 8'h00, 32'h1234, '0, '0);
    chk("R3 owner write err", 64'(r_err), 1);
    do_req(2'd1, 8'h04, 32'h1234, '0, '0);
    chk("R3 owner lo write err", 64'(r_err), 1);
    rd(8'h04);
    chk("R3 owner lo unchanged", r_data, 0);
    do_req(2'd2, 8'h00, '0, 64'h5, OWN_A);
    chk("R2 cas miss returns old", r_data, NO_OWN);
    rd(8'h00);
    chk("R2 cas miss keeps owner", r_data, 64'hFFFF0000);
    do_req(2'd2, 8'h04, '0, NO_OWN, OWN_A);
    chk("R2 cas at 0x04 err", 64'(r_err), 1);
    do_req(2'd2, 8'h00, '0, NO_OWN, OWN_A);
    chk("R2 cas hit ok", 64'(r_err), 0);
    chk("R2 cas hit returns old", r_data, NO_OWN);
    rd(8'h00);
    chk("R2 owner hi after swap", r_data, 64'h00010000);
    rd(8'h04);
    chk("R2 owner lo after swap", r_data, 64'h1000);
  endtask

  task automatic pulse_cfg(input logic rx, input logic tx);
    @(negedge clk_i);
    rx_cfg_chg_i = rx; tx_cfg_chg_i = tx;
    @(posedge clk_i);
    @(negedge clk_i);
    rx_cfg_chg_i = 1'b0; tx_cfg_chg_i = 1'b0;
  endtask

  task automatic t_clksel_ntf();
    ntf_ready_i = 1'b0;
    do_req(2'd1, 8'h0C, 32'hFFFF_060C, '0, '0);
    chk("R5 clk_sel write ok", 64'(r_err), 0);
    chk("R5 clk_sel_o", 64'(clk_sel_o), 64'h060C);
    chk("R8 ntf valid", 64'(ntf_valid_o), 1);
    chk("R5 accepted event data", 64'(ntf_data_o), 64'h20);
    chk("R8 ntf addr", ntf_addr_o, OWN_A);
    rd(8'h0C);
    chk("R5 clk_sel readback", r_data, 64'h060C);
    rd(8'h08);
    chk("R7 events reg", r_data, 64'h20);
    pulse_cfg(1'b1, 1'b0);
    pulse_cfg(1'b0, 1'b1);
    chk("R8 stalled data stable", 64'(ntf_data_o), 64'h20);
    rd(8'h08);
    chk("R7 new events replace", r_data, 64'h02);
    @(negedge clk_i);
    ntf_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 merged ntf valid", 64'(ntf_valid_o), 1);
    chk("R10 merged ntf data", 64'(ntf_data_o), 64'h03);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 ntf drops after accept", 64'(ntf_valid_o), 0);
  endtask

  task automatic t_enable();
    do_req(2'd1, 8'h10, 32'h0000_0100, '0, '0);
    chk("R6 enable set", 64'(stream_en_o), 1);
    rd(8'h10);
    chk("R6 enable readback", r_data, 1);
    do_req(2'd1, 8'h10, 32'h0, '0, '0);
    chk("R6 enable clear", 64'(stream_en_o), 0);
    do_req(2'd1, 8'h10, 32'h8000_0000, '0, '0);
    chk("R6 enable set by top bit", 64'(stream_en_o), 1);
  endtask

  task automatic t_src_lock();
    @(negedge clk_i);
    src_lock_i = 11'h005;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R11 src lock ntf", 64'(ntf_valid_o), 1);
    chk("R11 src lock event bit6", 64'(ntf_data_o), 64'h40);
    rd(8'h18);
    chk("R11 src lock readback", r_data, 64'h005);
    @(negedge clk_i);
    src_lock_i = 11'h405; cur_locked_i = 1'b1; cur_rate_i = 8'h02;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R11 both lock events", 64'(ntf_data_o), 64'h50);
    rd(8'h14);
    chk("R11 clock status", r_data, 64'h0201);
    rd(8'h08);
    chk("R7 events reg both", r_data, 64'h50);
  endtask

  task automatic t_slip();
    @(negedge clk_i);
    src_slip_i = 11'h008;
    @(posedge clk_i);
    @(negedge clk_i);
    src_slip_i = '0;
    chk("R12 slip no ntf", 64'(ntf_valid_o), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R12 slip no ntf later", 64'(ntf_valid_o), 0);
    rd(8'h18);
    chk("R12 slip sticky", r_data, 64'h0008_0405);
    rd(8'h18);
    chk("R12 slip cleared by read", r_data, 64'h405);
    @(negedge clk_i);
    src_slip_i = 11'h001;
    req_valid_i = 1'b1; req_op_i = 2'd0; req_addr_i = 8'h18;
    @(posedge clk_i);
    @(negedge clk_i);
    src_slip_i = '0; req_valid_i = 1'b0;
    chk("R12 read during slip old value", rsp_rdata_o, 64'h405);
    rd(8'h18);
    chk("R12 slip in read cycle kept", r_data, 64'h0001_0405);
  endtask

  task automatic t_no_owner();
    @(negedge clk_i);
    bus_reset_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_reset_i = 1'b0;
    chk("R1 bus reset clears enable", 64'(stream_en_o), 0);
    rd(8'h00);
    chk("R1 bus reset owner", r_data, 64'hFFFF0000);
    pulse_cfg(1'b1, 1'b0);
    chk("R9 no ntf without owner", 64'(ntf_valid_o), 0);
    rd(8'h08);
    chk("R9 event latched", r_data, 64'h01);
    do_req(2'd2, 8'h00, '0, NO_OWN, OWN_B);
    chk("R9 no ntf at claim edge", 64'(ntf_valid_o), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 ntf after claim", 64'(ntf_valid_o), 1);
    chk("R9 ntf data after claim", 64'(ntf_data_o), 64'h01);
    chk("R9 ntf addr after claim", ntf_addr_o, OWN_B);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_access_rules();
    t_owner();
    t_clksel_ntf();
    t_enable();
    t_src_lock();
    t_slip();
    t_no_owner();
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule